// File: doc/BRIEF.md
# Debounced Button Change Reporter

This block watches six pushbutton lines and tells a host only about real, settled changes. A free-running counter produces one sampling tick every `TICK_CYCLES` system clocks; a typical setting gives a 10 ms tick. At each tick the raw button lines are captured. A capture counts as settled only when it equals the capture taken at the tick before. A settled capture that differs from the pattern last handed to the host becomes the new reported pattern, and a change request flag is raised. The host reads the report byte and pulses a clear strobe to drop the flag.

A two-state machine tracks whether a candidate change is waiting for confirmation. In `ST_SETTLED`, the previous capture equals the reported pattern. In `ST_PENDING`, the previous capture differs from the reported pattern and waits for a second, agreeing capture. The transitions, all taken only on a tick, are as follows. `GO_PENDING`: from settled, the capture differs from the reported pattern. `CONFIRM`: from pending, the capture agrees with the previous one, a report fires, and the machine returns to settled. `REVERT`: from pending, the capture equals the reported pattern again. `RETRY`: from pending, the capture is a new, different value, and the machine stays pending. Every other tick holds the current state.

Top module: `btn_change_reporter`

## Requirements
- R1: After reset, `report` is 0x00, `change_req` is 0, and the stored previous capture and reported pattern are all zeros (no buttons pressed). An all-zero input held after reset therefore never raises a request.
- R2: Samples are taken only on tick edges. The first tick edge is the `TICK_CYCLES`-th rising clock edge after reset is released, and each later tick edge follows the one before it by exactly `TICK_CYCLES` edges. `report` never changes on any other edge.
- R3: A capture is settled only when it equals the capture taken at the immediately preceding tick. A value seen at a single tick is never reported.
- R4: The previous capture is replaced at every tick, whether or not that capture was settled.
- R5: A settled capture equal to the last reported pattern changes nothing: `report` keeps its value and `change_req` is not set.
- R6: A settled capture that differs from the last reported pattern is stored as the reported pattern, and `change_req` is set, both on that tick edge.
- R7: The report byte layout is as follows. Bit 7 is 0. Bits 6, 5 and 4 carry `btn_raw[5]`, `btn_raw[4]` and `btn_raw[3]` (buttons 6, 5, 4). Bit 3 is 0. Bits 2, 1 and 0 carry `btn_raw[2]`, `btn_raw[1]` and `btn_raw[0]` (buttons 2, 1, 0).
- R8: `change_req` stays set until `req_clr` is high at a clock edge, which clears it on that edge.
- R9: When `req_clr` is high on the same edge on which a report fires, `change_req` ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_raw | input | 6 | Raw button levels; bits 5..3 are buttons 6..4, bits 2..0 are buttons 2..0 |
| req_clr | input | 1 | Clear strobe for the change request |
| report | output | 8 | Last reported pattern in report byte layout |
| change_req | output | 1 | Change request flag for the host |

## Verification
The hardest situation to reach from the ports is a clear strobe that lands exactly on the tick edge where a report fires. The tick is not visible at the ports. The bench reaches this case by counting clocks from the release of reset: it holds each input pattern for exactly one tick period and raises `req_clr` only in the final cycle of that period. Every one of the 64 patterns is first captured once, which must not report, and then captured again, which must report. The bench rotates between no clear, an early clear and a coincident clear, and checks just before each tick that `report` has not yet moved.

// File: rtl/btnrep_pkg.sv
package btnrep_pkg;

    localparam int BTN_W = 6;
    localparam int REP_W = 8;

    typedef enum logic [0:0] {
        ST_SETTLED = 1'b0,
        ST_PENDING = 1'b1
    } rep_state_e;

    // Spread the six buttons into the report byte, leaving bits 7 and 3 at zero.
    function automatic logic [REP_W-1:0] pack_report(input logic [BTN_W-1:0] b);
        return {1'b0, b[5:3], 1'b0, b[2:0]};
    endfunction

endpackage

// File: rtl/btnrep_tick.sv
module btnrep_tick #(
    parameter int TICK_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/btnrep_core.sv
module btnrep_core
    import btnrep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [BTN_W-1:0] sample,
    input  logic             req_clr,
    output logic [BTN_W-1:0] last_sent,
    output logic             req
);
    rep_state_e       state_q, state_d;
    logic [BTN_W-1:0] prev_q;
    logic [BTN_W-1:0] last_q;
    logic             req_q;
    logic             agree;
    logic             differs;
    logic             fire;

    assign agree   = (sample == prev_q);
    assign differs = (sample != last_q);
    assign fire    = tick && agree && differs;

    // state register together with the data it qualifies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SETTLED;
            prev_q  <= '0;
            last_q  <= '0;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (tick) prev_q <= sample;
            if (fire) last_q <= sample;
            if (fire)         req_q <= 1'b1;
            else if (req_clr) req_q <= 1'b0;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETTLED: begin
                if (tick && differs) state_d = ST_PENDING;   // GO_PENDING
            end
            ST_PENDING: begin
                if (tick) begin
                    if (fire || !differs) state_d = ST_SETTLED; // CONFIRM / REVERT
                    else                  state_d = ST_PENDING; // RETRY
                end
            end
            default: state_d = ST_SETTLED;
        endcase
    end

    assign last_sent = last_q;
    assign req       = req_q;

    // R2
    off_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(last_q));

    // R5
    same_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sample == last_q) |=> ($stable(last_q) && (req_q == $past(req_q && !req_clr))));

    // R5
    settled_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLED) |-> (prev_q == last_q));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !req_clr) |=> req_q);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sample == prev_q && sample != last_q && req_clr) |=> req_q);

    // R3
    single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sample != prev_q) |=> $stable(last_q));

endmodule

// File: rtl/btn_change_reporter.sv
module btn_change_reporter
    import btnrep_pkg::*;
#(
    parameter int TICK_CYCLES = 500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BTN_W-1:0] btn_raw,
    input  logic             req_clr,
    output logic [REP_W-1:0] report,
    output logic             change_req
);
    logic             tick;
    logic [BTN_W-1:0] last_sent;

    btnrep_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    btnrep_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sample    (btn_raw),
        .req_clr   (req_clr),
        .last_sent (last_sent),
        .req       (change_req)
    );

    assign report = pack_report(last_sent);

    // R7
    spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (report[7] == 1'b0) && (report[3] == 1'b0));

endmodule

// File: tb/btn_change_reporter_bench.sv
module btn_change_reporter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T          = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] btn_raw;
    logic       req_clr;
    logic [7:0] report;
    logic       change_req;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    // bench model state, derived from the requirements
    logic [5:0] m_prev;
    logic [5:0] m_last;
    logic       m_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    btn_change_reporter #(.TICK_CYCLES(T)) u_btn_change_reporter (
        .clk        (clk),
        .rst_n      (rst_n),
        .btn_raw    (btn_raw),
        .req_clr    (req_clr),
        .report     (report),
        .change_req (change_req)
    );

    function automatic logic [7:0] layout(input logic [5:0] b);
        logic [7:0] r;
        r = 8'h00;
        r[6] = b[5]; r[5] = b[4]; r[4] = b[3];
        r[2] = b[2]; r[1] = b[1]; r[0] = b[0];
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] rep_exp, input logic req_exp);
        n_vec++;
        if (report !== rep_exp || change_req !== req_exp) begin
            n_miss++;
            $display("FAIL %s: report=%h change_req=%b expected report=%h change_req=%b",
                     req, report, change_req, rep_exp, req_exp);
        end
    endtask

    // One tick period: the pattern is held for T edges, the last of which is the tick edge.
    // mode 0: no clear, 1: clear on the first edge of the period, 2: clear on the tick edge.
    task automatic period(input logic [5:0] p, input int mode, input string tag);
        logic fire;
        btn_raw = p;
        for (int i = 0; i < T; i++) begin
            req_clr = (mode == 1 && i == 0) || (mode == 2 && i == T-1);
            if (i == T-1) begin
                // R2: nothing moves before the tick edge
                check("R2", layout(m_last), (mode == 1) ? 1'b0 : m_req);
            end
            @(posedge clk);
            @(negedge clk);
        end
        req_clr = 1'b0;
        if (mode == 1) m_req = 1'b0;
        fire = (p == m_prev) && (p != m_last);
        if (fire) begin
            m_last = p;
            m_req  = 1'b1;
        end else if (mode == 2) begin
            m_req = 1'b0;
        end
        m_prev = p;
        check(tag, layout(m_last), m_req);
    endtask

    initial begin
        rst_n   = 1'b0;
        btn_raw = 6'h00;
        req_clr = 1'b0;
        m_prev  = 6'h00;
        m_last  = 6'h00;
        m_req   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 8'h00, 1'b0);
        rst_n = 1'b1;

        // R1: all-zero input right after reset raises nothing
        period(6'h00, 0, "R1");
        period(6'h00, 0, "R1");

        // R3/R4: glitch a-b-a, never two equal captures in a row
        period(6'h15, 0, "R3");
        period(6'h2A, 0, "R4");
        period(6'h15, 0, "R4");
        // second agreeing capture reports, with the R7 layout
        period(6'h15, 0, "R6");
        // R8: flag holds without a clear
        period(6'h15, 0, "R8");
        // R5: same pattern, early clear drops the flag, no re-report
        period(6'h15, 1, "R8");
        period(6'h15, 0, "R5");

        // exhaustive sweep over all button patterns
        for (int v = 0; v < 64; v++) begin
            period(6'(v ^ 6'h3F), 0, "R3");
            period(6'(v ^ 6'h3F), v % 3, "R7");
            period(6'(v), 0, "R4");
            period(6'(v), (v % 2 == 0) ? 2 : 1, "R9");
        end

        // R9: clear coincident with a firing tick leaves the flag set
        period(6'h09, 1, "R3");
        period(6'h09, 2, "R9");
        // R5: settled repeat of the reported pattern with a coincident clear
        period(6'h09, 2, "R5");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_vec++;
                n_miss++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule